// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block controls a low-power standby state for a small processor-style system. Software asks for standby with a one-cycle request. While the bus-release enable is off, the block accepts the request. It then drops the system clock enable and the oscillator enable and waits for a wake event. The wake path depends on the event. An interrupt wake restarts the oscillator and waits a programmable settling time before clocks return. A reset wake supplies clocks at once and resumes when the reset pin is released. A low hardware-standby pin overrides everything and shuts the system down.

The settling time is counted in clock cycles while the oscillator runs. Its length is 2^(SETTLE_BASE + select + divider) cycles. The select is a 3-bit field and the divider is a 2-bit field, and both are sampled in the cycle the wake event is taken. Software is expected to choose settings that cover the oscillator's start-up time. A crystal needs 7 ms or more and an external clock needs 100 µs or more. When the system resumes, the block emits a one-cycle wake pulse. A cause code, held until the next wake or hardware standby, names the event that ended standby.

Top module: `standby_wake_seq`

## Requirements
- R1: After the block reset `rst_n`, the outputs read: `sys_clk_en`=1, `osc_en`=1, `standby_active`=0, `hw_standby`=0, `wake_pulse`=0 and `wake_cause`=0.
- R2: Suppose `sleep_req` is high in the running state, `bus_rel_en`=0 and `hw_stby_n`=1. In the next cycle `standby_active`=1, `sys_clk_en`=0 and `osc_en`=0. `sleep_req` has no effect in any other state.
- R3: If `sleep_req` arrives while `bus_rel_en`=1, the request is refused. The block stays running, with `sys_clk_en`=1 and `standby_active`=0.
- R4: A high `nmi` in standby sets `osc_en`=1 in the next cycle. `sys_clk_en` then stays 0 for exactly L = 2^(2 + `settle_sel` + `div_sel`) cycles, and after that it returns to 1. The minimum is L=4 and the maximum is L=4096.
- R5: External line n wakes the block only when `irq[n]`=1, `irq_en[n]`=1 and `irq_mask`=0. It then follows the R4 settling path and reports cause 4+n. When several lines qualify, the lowest index wins.
- R6: A line that is disabled (`irq_en[n]`=0) is ignored, and so is any external line while `irq_mask`=1. The block stays in standby with `osc_en`=0 and `sys_clk_en`=0.
- R7: A low `rst_pin_n` during standby or settling gives `sys_clk_en`=1, `osc_en`=1 and `standby_active`=0 in the next cycle, with no settling count. The block resumes when `rst_pin_n` returns high, and the cause is 2.
- R8: A low `hw_stby_n` in any state gives `hw_standby`=1, `standby_active`=1, `sys_clk_en`=0 and `osc_en`=0 in the next cycle, and the cause is 1. When the pin goes high, clocks return in the reset-hold state, and the block resumes after `rst_pin_n` is high.
- R9: Wake events arriving in the same cycle are ranked as follows: the hardware-standby pin first, then the reset pin, then `nmi`, then the external lines. The cause codes are 1 for hardware standby, 2 for reset, 3 for NMI and 4+n for external line n.
- R10: `wake_pulse` is high for exactly one cycle, the first running cycle after a wake. At that cycle `wake_cause` holds the cause of the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | One-cycle software request to enter standby |
| bus_rel_en | input | 1 | Bus-release enable; entry is refused while it is high |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | 3 | External interrupt request lines |
| irq_en | input | 3 | Per-line enable bits for the external lines |
| irq_mask | input | 1 | CPU mask for all external lines |
| rst_pin_n | input | 1 | Active-low system reset pin |
| hw_stby_n | input | 1 | Active-low hardware-standby pin |
| settle_sel | input | 3 | Settling-time select |
| div_sel | input | 2 | Clock-divider setting that scales the settling time |
| sys_clk_en | output | 1 | System clock enable |
| osc_en | output | 1 | Oscillator enable |
| standby_active | output | 1 | High while in software or hardware standby, including settling |
| hw_standby | output | 1 | High while in hardware standby |
| wake_pulse | output | 1 | One-cycle pulse when the system resumes |
| wake_cause | output | 3 | Code of the event that caused the last wake |

## Verification
The case that matters most is several wake sources hitting the same standby cycle. In that cycle the priority rule and the clock path, immediate or counted, must agree. The bench raises two sources together: NMI with an external line, two external lines, reset with NMI, and the hardware-standby pin with reset. For each pair it checks the cause code and whether clocks return at once or after the computed settle length. A reset that arrives partway through a settling count is also provoked. It must abandon the count and restore clocks in the next cycle.

// File: rtl/standby_wake_seq.sv
module standby_wake_seq #(
  parameter int SETTLE_BASE = 2,
  parameter int SEL_W       = 3,
  parameter int DIV_W       = 2,
  parameter int N_IRQ       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             bus_rel_en,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_mask,
  input  logic             rst_pin_n,
  input  logic             hw_stby_n,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sys_clk_en,
  output logic             osc_en,
  output logic             standby_active,
  output logic             hw_standby,
  output logic             wake_pulse,
  output logic [$clog2(4+N_IRQ)-1:0] wake_cause
);
  localparam int MAX_EXP = SETTLE_BASE + (1 << SEL_W) - 1 + (1 << DIV_W) - 1;
  localparam int CW      = MAX_EXP + 1;
  localparam int EW      = $clog2(MAX_EXP + 1);
  localparam int CAUSE_W = $clog2(4 + N_IRQ);
  localparam logic [CAUSE_W-1:0] C_HW  = CAUSE_W'(1);
  localparam logic [CAUSE_W-1:0] C_RST = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] C_NMI = CAUSE_W'(3);

  typedef enum logic [2:0] {S_RUN, S_STBY, S_SETTLE, S_HW, S_RHOLD} st_t;

  st_t               st, nxt;
  logic [CW-1:0]     cnt;
  logic [CAUSE_W-1:0] cause, ncause, ext_code;
  logic              ext_hit, load, pulse_n;
  logic [N_IRQ-1:0]  ext_req;
  logic [EW-1:0]     exp_w;
  logic [CW-1:0]     load_val;

  assign ext_req  = irq & irq_en & {N_IRQ{~irq_mask}};
  assign ext_hit  = |ext_req;
  assign exp_w    = EW'(SETTLE_BASE) + EW'(settle_sel) + EW'(div_sel);
  assign load_val = (CW'(1) << exp_w) - CW'(1);

  always_comb begin
    ext_code = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (ext_req[i]) ext_code = CAUSE_W'(4 + i);
  end

  always_comb begin
    nxt     = st;
    ncause  = cause;
    load    = 1'b0;
    pulse_n = 1'b0;
    if (!hw_stby_n) begin
      nxt    = S_HW;
      ncause = C_HW;
    end else begin
      case (st)
        S_RUN:    if (sleep_req && !bus_rel_en) nxt = S_STBY;
        S_STBY: begin
          if (!rst_pin_n) begin
            nxt = S_RHOLD; ncause = C_RST;
          end else if (nmi) begin
            nxt = S_SETTLE; ncause = C_NMI; load = 1'b1;
          end else if (ext_hit) begin
            nxt = S_SETTLE; ncause = ext_code; load = 1'b1;
          end
        end
        S_SETTLE: begin
          if (!rst_pin_n) begin
            nxt = S_RHOLD; ncause = C_RST;
          end else if (cnt == '0) begin
            nxt = S_RUN; pulse_n = 1'b1;
          end
        end
        S_HW:     nxt = S_RHOLD;
        S_RHOLD:  if (rst_pin_n) begin nxt = S_RUN; pulse_n = 1'b1; end
        default:  nxt = S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cnt        <= '0;
      cause      <= '0;
      wake_pulse <= 1'b0;
    end else begin
      st         <= nxt;
      cause      <= ncause;
      wake_pulse <= pulse_n;
      if (load)                 cnt <= load_val;
      else if (st == S_SETTLE && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign sys_clk_en     = (st == S_RUN) || (st == S_RHOLD);
  assign osc_en         = (st == S_RUN) || (st == S_RHOLD) || (st == S_SETTLE);
  assign standby_active = (st == S_STBY) || (st == S_SETTLE) || (st == S_HW);
  assign hw_standby     = (st == S_HW);
  assign wake_cause     = cause;

  // R2
  clk_vs_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en |-> !standby_active);
  // R3
  refuse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_req && bus_rel_en && hw_stby_n) |=> sys_clk_en && !standby_active);
  // R4
  settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && $past(st) == S_SETTLE) |-> cnt == $past(cnt) - 1'b1);
  // R7
  reset_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_active && !hw_standby && hw_stby_n && !rst_pin_n) |=> sys_clk_en && osc_en);
  // R8
  hw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_stby_n |=> hw_standby && !sys_clk_en && !osc_en && wake_cause == C_HW);
  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  // R10
  pulse_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> sys_clk_en && wake_cause != '0);
endmodule

// File: tb/standby_wake_seq_tb.sv
module standby_wake_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, bus_rel_en = 0, nmi = 0, irq_mask = 0;
  logic rst_pin_n = 1, hw_stby_n = 1;
  logic [2:0] irq = 0, irq_en = 0, settle_sel = 0;
  logic [1:0] div_sel = 0;
  logic sys_clk_en, osc_en, standby_active, hw_standby, wake_pulse;
  logic [2:0] wake_cause;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_rel_en(bus_rel_en),
    .nmi(nmi), .irq(irq), .irq_en(irq_en), .irq_mask(irq_mask),
    .rst_pin_n(rst_pin_n), .hw_stby_n(hw_stby_n), .settle_sel(settle_sel),
    .div_sel(div_sel), .sys_clk_en(sys_clk_en), .osc_en(osc_en),
    .standby_active(standby_active), .hw_standby(hw_standby),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause));

  // reference model: 0 run, 1 standby, 2 settling, 3 hw standby, 4 reset hold
  int m_mode = 0, m_left = 0, m_cause = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_left <= 0; m_cause <= 0; m_pulse <= 0;
    end else begin
      int mode, left, cause, pulse, winner;
      mode = m_mode; left = m_left; cause = m_cause; pulse = 0;
      winner = -1;
      for (int n = 2; n >= 0; n--)
        if (irq[n] && irq_en[n] && !irq_mask) winner = n;
      if (!hw_stby_n) begin
        mode = 3; cause = 1;
      end else if (m_mode == 0) begin
        if (sleep_req && !bus_rel_en) mode = 1;
      end else if (m_mode == 1) begin
        if (!rst_pin_n) begin mode = 4; cause = 2; end
        else if (nmi || winner >= 0) begin
          mode = 2;
          cause = nmi ? 3 : 4 + winner;
          left = (1 << (2 + settle_sel + div_sel)) - 1;
        end
      end else if (m_mode == 2) begin
        if (!rst_pin_n) begin mode = 4; cause = 2; end
        else if (left == 0) begin mode = 0; pulse = 1; end
        else left = left - 1;
      end else if (m_mode == 3) begin
        mode = 4;
      end else begin
        if (rst_pin_n) begin mode = 0; pulse = 1; end
      end
      m_mode <= mode; m_left <= left; m_cause <= cause; m_pulse <= pulse;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R2 sys_clk_en", sys_clk_en, (m_mode == 0 || m_mode == 4));
    chk("R4 osc_en", osc_en, (m_mode == 0 || m_mode == 2 || m_mode == 4));
    chk("R2 standby_active", standby_active, (m_mode >= 1 && m_mode <= 3));
    chk("R8 hw_standby", hw_standby, (m_mode == 3));
    chk("R10 wake_pulse", wake_pulse, m_pulse);
    chk("R9 wake_cause", wake_cause, m_cause);
  endtask

  task automatic enter_standby();
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R2 entered", standby_active, 1);
    chk("R2 clocks off", sys_clk_en, 0);
  endtask

  task automatic expect_settle(input string tag, input int len, input int cause);
    int n = 0;
    while (!sys_clk_en && n < 10000) begin
      chk({tag, " osc on while settling"}, osc_en, 1);
      n++; tick();
    end
    chk({tag, " settle length"}, n, len);
    chk({tag, " wake pulse"}, wake_pulse, 1);
    chk({tag, " cause"}, wake_cause, cause);
    tick();
    chk("R10 pulse one cycle", wake_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1
    chk("R1 sys_clk_en", sys_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 standby_active", standby_active, 0);
    chk("R1 hw_standby", hw_standby, 0);
    chk("R1 wake_pulse", wake_pulse, 0);
    chk("R1 wake_cause", wake_cause, 0);

    // R3 refused entry
    bus_rel_en = 1; sleep_req = 1; tick(); sleep_req = 0; bus_rel_en = 0;
    chk("R3 still running", sys_clk_en, 1);
    chk("R3 not in standby", standby_active, 0);
    tick();

    // R6 ignored lines, then R4 NMI wake with L=8
    enter_standby();
    irq = 3'b001; irq_en = 3'b000; tick();
    chk("R6 disabled line", osc_en, 0);
    irq = 3'b010; irq_en = 3'b010; irq_mask = 1; tick();
    chk("R6 masked line", standby_active, 1);
    chk("R6 masked line osc", osc_en, 0);
    irq = 0; irq_en = 0; irq_mask = 0;
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R2 request ignored in standby", sys_clk_en, 0);
    settle_sel = 1; div_sel = 0; nmi = 1; tick(); nmi = 0;
    expect_settle("R4 nmi", 8, 3);

    // R5 external line 2, L=16
    enter_standby();
    settle_sel = 0; div_sel = 2; irq = 3'b100; irq_en = 3'b111; tick(); irq = 0;
    expect_settle("R5 irq2", 16, 6);

    // R5 R9 two lines together, lowest wins, L=4
    enter_standby();
    settle_sel = 0; div_sel = 0; irq = 3'b101; tick(); irq = 0;
    expect_settle("R5 irq0 over irq2", 4, 4);

    // R9 nmi over external
    enter_standby();
    settle_sel = 2; nmi = 1; irq = 3'b010; tick(); nmi = 0; irq = 0;
    expect_settle("R9 nmi over irq1", 16, 3);

    // R7 R9 reset with nmi: immediate clocks
    enter_standby();
    rst_pin_n = 0; nmi = 1; tick(); nmi = 0;
    chk("R7 immediate clocks", sys_clk_en, 1);
    chk("R7 cause reset", wake_cause, 2);
    repeat (4) tick();
    chk("R7 no pulse while held", wake_pulse, 0);
    rst_pin_n = 1; tick();
    chk("R7 resume pulse", wake_pulse, 1);
    tick();

    // R7 reset during settling
    enter_standby();
    settle_sel = 4; nmi = 1; tick(); nmi = 0;
    repeat (5) tick();
    rst_pin_n = 0; tick();
    chk("R7 settle abandoned", sys_clk_en, 1);
    rst_pin_n = 1; tick();
    chk("R7 pulse after abandon", wake_pulse, 1);
    chk("R7 cause after abandon", wake_cause, 2);
    tick();

    // R8 R9 hw pin with reset in standby
    enter_standby();
    hw_stby_n = 0; rst_pin_n = 0; tick();
    chk("R8 hw standby", hw_standby, 1);
    chk("R9 hw over reset", wake_cause, 1);
    rst_pin_n = 1; repeat (3) tick();
    hw_stby_n = 1; tick();
    chk("R8 clocks in reset hold", sys_clk_en, 1);
    tick();
    chk("R8 resume pulse", wake_pulse, 1);
    chk("R8 resume cause", wake_cause, 1);
    tick();

    // R8 from running
    hw_stby_n = 0; tick(); hw_stby_n = 1;
    chk("R8 from run", hw_standby, 1);
    chk("R8 osc off", osc_en, 0);
    repeat (3) tick();

    // R4 maximum settle L=4096
    enter_standby();
    settle_sel = 7; div_sel = 3; nmi = 1; tick(); nmi = 0;
    expect_settle("R4 max", 4096, 3);
    repeat (3) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule